// File: doc/BRIEF.md
# Fairness-Aware DRAM Request Scheduler

This block picks the next DRAM request to issue from a shared buffer of sixteen pending requests. The buffer serves four hardware threads spread across eight banks. The block holds the buffer contents and the row left open in each bank. Every cycle it offers at most one winning entry index. A consumer accepts the offer by raising `gnt_ready`.

Selection runs in two stages. In the first stage, each bank finds two candidates among its own entries. The throughput candidate favours open-row hits and then age. The fairness candidate is the oldest entry of the most slowed-down thread that has work at that bank. A mode bit picks which candidate each bank offers. The mode bit is set when the measured unfairness is strictly greater than a programmable limit. In the second stage, the block chooses among the banks' offers. In throughput mode the oldest offer wins. In fairness mode the offer with the highest slowdown wins.

Slowdown indices and the unfairness level are computed outside this block and arrive as inputs. DRAM command timing is also handled elsewhere.

Top module: `fair_dram_sched`

## Requirements
- R1: After reset, all sixteen entries are empty and no bank has an open row, so `gnt_valid` is 0.
- R2: When `ld_en` is high, slot `ld_idx` takes the thread, bank, row and stamp fields and becomes valid on the next cycle. A load takes precedence over a retirement of the same slot in the same cycle.
- R3: When no entry is valid, `gnt_valid` stays 0. When `gnt_valid` is 1, `gnt_idx` names a valid entry.
- R4: In throughput mode, an entry is a hit when its bank has an open row and the entry's row equals that row. A hit is preferred over any non-hit entry of the same bank.
- R5: In throughput mode, among entries of one bank with equal hit status, the smaller stamp (older, compared unsigned) wins. Equal stamps go to the lower slot index.
- R6: In throughput mode, the bank offer with the smallest stamp is granted. Equal stamps go to the lower bank number.
- R7: Fairness mode is active exactly when `unfair_level > unfair_limit` (unsigned), and `gnt_fair` shows the mode. When the two values are equal, throughput mode applies.
- R8: In fairness mode, each bank offers the entry whose thread has the highest slowdown among that bank's entries. Ties go to the older stamp, then the lower slot index. The slowdown of thread t is `slowdown[8*t+7:8*t]`.
- R9: In fairness mode, the offer with the highest thread slowdown is granted. Ties go to the older stamp, then the lower bank number.
- R10: When `gnt_valid` and `gnt_ready` are both high, the granted slot is invalid on the next cycle. The granted bank then has an open row equal to the granted entry's row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Write a request into the buffer |
| ld_idx | input | 4 | Slot to write |
| ld_thread | input | 2 | Thread of the new request |
| ld_bank | input | 3 | Bank of the new request |
| ld_row | input | 8 | Row of the new request |
| ld_stamp | input | 8 | Arrival stamp (smaller is older) |
| slowdown | input | 32 | Four 8-bit slowdown indices, thread 0 in the low byte |
| unfair_level | input | 8 | Measured system unfairness |
| unfair_limit | input | 8 | Unfairness threshold |
| gnt_ready | input | 1 | Consumer accepts the current grant |
| gnt_valid | output | 1 | A grant is offered |
| gnt_idx | output | 4 | Slot of the granted request |
| gnt_fair | output | 1 | Grant chosen in fairness mode |

## Verification
The assertions check several properties on every cycle:
- no grant is offered while the buffer is empty, and any grant points at a live slot;
- an accepted slot is retired and its row opened on the next cycle;
- in throughput mode, a grant never bypasses a hit in its own bank;
- in fairness mode, no valid entry belongs to a thread with a higher slowdown than the granted one.

Only the bench scenarios can show the full tie-break orderings by age, slot index and bank number, the boundary where the unfairness level equals the limit, and a load that overrides a same-cycle retirement. The bench checks these against an independent model of the buffer.

// File: rtl/fsched_pkg.sv
package fsched_pkg;
  localparam int unsigned N_ENT   = 16;
  localparam int unsigned N_THR   = 4;
  localparam int unsigned N_BANK  = 8;
  localparam int unsigned ROW_W   = 8;
  localparam int unsigned STAMP_W = 8;
  localparam int unsigned SD_W    = 8;
  localparam int unsigned LVL_W   = 8;
  localparam int unsigned IDX_W   = $clog2(N_ENT);
  localparam int unsigned TID_W   = $clog2(N_THR);
  localparam int unsigned BANK_W  = $clog2(N_BANK);
  localparam int unsigned SDV_W   = N_THR * SD_W;

  typedef logic [IDX_W-1:0]   idx_t;
  typedef logic [TID_W-1:0]   tid_t;
  typedef logic [BANK_W-1:0]  bank_t;
  typedef logic [ROW_W-1:0]   row_t;
  typedef logic [STAMP_W-1:0] stamp_t;
  typedef logic [SD_W-1:0]    sd_t;

  typedef struct packed {
    logic   vld;
    tid_t   tid;
    bank_t  bank;
    row_t   row;
    stamp_t stamp;
  } req_t;

  // throughput order: hit first, then older stamp
  function automatic logic base_wins(logic hit_a, stamp_t st_a, logic hit_b, stamp_t st_b);
    return (hit_a & ~hit_b) | ((hit_a == hit_b) & (st_a < st_b));
  endfunction

  // fairness order: larger slowdown first, then older stamp
  function automatic logic fair_wins(sd_t sd_a, stamp_t st_a, sd_t sd_b, stamp_t st_b);
    return (sd_a > sd_b) | ((sd_a == sd_b) & (st_a < st_b));
  endfunction

  function automatic sd_t sd_of(logic [SDV_W-1:0] vec, tid_t t);
    return vec[t*SD_W +: SD_W];
  endfunction

  function automatic logic over_limit(logic [LVL_W-1:0] lvl, logic [LVL_W-1:0] lim);
    return lvl > lim;
  endfunction
endpackage

// File: rtl/fsched_buf.sv
module fsched_buf
  import fsched_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_en,
  input  idx_t                    ld_idx,
  input  req_t                    ld_ent,
  input  logic                    acc,
  input  idx_t                    acc_idx,
  output req_t  [N_ENT-1:0]       ents,
  output logic  [N_BANK-1:0]      open_v,
  output logic  [N_BANK-1:0][ROW_W-1:0] open_row
);
  bank_t acc_bank;
  assign acc_bank = ents[acc_idx].bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ents     <= '0;
      open_v   <= '0;
      open_row <= '0;
    end else begin
      if (acc) begin
        ents[acc_idx].vld  <= 1'b0;
        open_v[acc_bank]   <= 1'b1;
        open_row[acc_bank] <= ents[acc_idx].row;
      end
      if (ld_en) begin
        ents[ld_idx]     <= ld_ent;
        ents[ld_idx].vld <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fsched_bank_pick.sv
module fsched_bank_pick
  import fsched_pkg::*;
#(
  parameter int unsigned BANK_ID = 0
) (
  input  req_t [N_ENT-1:0]  ents,
  input  logic              open_v,
  input  row_t              open_row,
  input  logic [SDV_W-1:0]  sd_vec,
  input  logic              fair_mode,
  output logic              offer_v,
  output idx_t              offer_idx,
  output stamp_t            offer_stamp,
  output sd_t               offer_sd,
  output logic              hit_any
);
  logic   b_v, f_v, b_hit, cur_hit;
  idx_t   b_idx, f_idx;
  stamp_t b_st, f_st;
  sd_t    b_sd, f_sd, cur_sd;

  always_comb begin
    b_v = 1'b0; b_idx = '0; b_st = '0; b_hit = 1'b0; b_sd = '0;
    f_v = 1'b0; f_idx = '0; f_st = '0; f_sd = '0;
    hit_any = 1'b0;
    cur_hit = 1'b0; cur_sd = '0;
    for (int i = 0; i < int'(N_ENT); i++) begin
      if (ents[i].vld && ents[i].bank == bank_t'(BANK_ID)) begin
        cur_hit = open_v && (ents[i].row == open_row);
        cur_sd  = sd_of(sd_vec, ents[i].tid);
        hit_any = hit_any | cur_hit;
        if (!b_v || base_wins(cur_hit, ents[i].stamp, b_hit, b_st)) begin
          b_v = 1'b1; b_idx = idx_t'(i); b_st = ents[i].stamp;
          b_hit = cur_hit; b_sd = cur_sd;
        end
        if (!f_v || fair_wins(cur_sd, ents[i].stamp, f_sd, f_st)) begin
          f_v = 1'b1; f_idx = idx_t'(i); f_st = ents[i].stamp; f_sd = cur_sd;
        end
      end
    end
  end

  assign offer_v     = fair_mode ? f_v   : b_v;
  assign offer_idx   = fair_mode ? f_idx : b_idx;
  assign offer_stamp = fair_mode ? f_st  : b_st;
  assign offer_sd    = fair_mode ? f_sd  : b_sd;
endmodule

// File: rtl/fsched_xbank.sv
module fsched_xbank
  import fsched_pkg::*;
(
  input  logic [N_BANK-1:0]              offer_v,
  input  logic [N_BANK-1:0][IDX_W-1:0]   offer_idx,
  input  logic [N_BANK-1:0][STAMP_W-1:0] offer_stamp,
  input  logic [N_BANK-1:0][SD_W-1:0]    offer_sd,
  input  logic                           fair_mode,
  output logic                           win_v,
  output idx_t                           win_idx,
  output bank_t                          win_bank
);
  stamp_t w_st;
  sd_t    w_sd;
  logic   beats;

  always_comb begin
    win_v = 1'b0; win_idx = '0; win_bank = '0; w_st = '0; w_sd = '0; beats = 1'b0;
    for (int b = 0; b < int'(N_BANK); b++) begin
      if (offer_v[b]) begin
        if (fair_mode) beats = fair_wins(offer_sd[b], offer_stamp[b], w_sd, w_st);
        else           beats = offer_stamp[b] < w_st;
        if (!win_v || beats) begin
          win_v = 1'b1; win_idx = offer_idx[b]; win_bank = bank_t'(b);
          w_st = offer_stamp[b]; w_sd = offer_sd[b];
        end
      end
    end
  end
endmodule

// File: rtl/fair_dram_sched.sv
module fair_dram_sched
  import fsched_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_en,
  input  logic [3:0]  ld_idx,
  input  logic [1:0]  ld_thread,
  input  logic [2:0]  ld_bank,
  input  logic [7:0]  ld_row,
  input  logic [7:0]  ld_stamp,
  input  logic [31:0] slowdown,
  input  logic [7:0]  unfair_level,
  input  logic [7:0]  unfair_limit,
  input  logic        gnt_ready,
  output logic        gnt_valid,
  output logic [3:0]  gnt_idx,
  output logic        gnt_fair
);
  req_t [N_ENT-1:0]              ent_q;
  logic [N_BANK-1:0]             open_v_q;
  logic [N_BANK-1:0][ROW_W-1:0]  open_row_q;
  logic [N_BANK-1:0]             bank_offer_v;
  logic [N_BANK-1:0][IDX_W-1:0]  bank_offer_idx;
  logic [N_BANK-1:0][STAMP_W-1:0] bank_offer_stamp;
  logic [N_BANK-1:0][SD_W-1:0]   bank_offer_sd;
  logic [N_BANK-1:0]             bank_hit_any;
  logic   fair_mode, accept, win_v;
  idx_t   win_idx;
  bank_t  win_bank;
  req_t   ld_ent;

  assign fair_mode = over_limit(unfair_level, unfair_limit);
  assign accept    = win_v & gnt_ready;
  assign ld_ent    = '{vld: 1'b1, tid: ld_thread, bank: ld_bank, row: ld_row, stamp: ld_stamp};

  fsched_buf u_buf (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_ent(ld_ent),
    .acc(accept), .acc_idx(win_idx), .ents(ent_q), .open_v(open_v_q), .open_row(open_row_q)
  );

  for (genvar b = 0; b < int'(N_BANK); b++) begin : g_bank
    fsched_bank_pick #(.BANK_ID(b)) u_pick (
      .ents(ent_q), .open_v(open_v_q[b]), .open_row(open_row_q[b]), .sd_vec(slowdown),
      .fair_mode(fair_mode), .offer_v(bank_offer_v[b]), .offer_idx(bank_offer_idx[b]),
      .offer_stamp(bank_offer_stamp[b]), .offer_sd(bank_offer_sd[b]), .hit_any(bank_hit_any[b])
    );
  end

  fsched_xbank u_xbank (
    .offer_v(bank_offer_v), .offer_idx(bank_offer_idx), .offer_stamp(bank_offer_stamp),
    .offer_sd(bank_offer_sd), .fair_mode(fair_mode),
    .win_v(win_v), .win_idx(win_idx), .win_bank(win_bank)
  );

  assign gnt_valid = win_v;
  assign gnt_idx   = win_idx;
  assign gnt_fair  = fair_mode;
endmodule

// File: rtl/fsched_chk.sv
module fsched_chk
  import fsched_pkg::*;
(
  input logic                         clk,
  input logic                         rst_n,
  input req_t [N_ENT-1:0]             ents,
  input logic [N_BANK-1:0]            open_v,
  input logic [N_BANK-1:0][ROW_W-1:0] open_row,
  input logic [N_BANK-1:0]            hit_any,
  input logic [SDV_W-1:0]             slowdown,
  input logic                         ld_en,
  input idx_t                         ld_idx,
  input logic                         gnt_ready,
  input logic                         gnt_valid,
  input idx_t                         gnt_idx,
  input logic                         gnt_fair
);
  logic  any_vld, gnt_hit, p_acc, p_ovr;
  sd_t   sd_max;
  idx_t  p_idx;
  bank_t g_bank, p_bank;
  row_t  p_row;

  assign g_bank  = ents[gnt_idx].bank;
  assign gnt_hit = open_v[g_bank] && (open_row[g_bank] == ents[gnt_idx].row);

  always_comb begin
    any_vld = 1'b0;
    sd_max  = '0;
    for (int i = 0; i < int'(N_ENT); i++) begin
      if (ents[i].vld) begin
        any_vld = 1'b1;
        if (sd_of(slowdown, ents[i].tid) > sd_max) sd_max = sd_of(slowdown, ents[i].tid);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_acc <= 1'b0; p_ovr <= 1'b0; p_idx <= '0; p_bank <= '0; p_row <= '0;
    end else begin
      p_acc  <= gnt_valid & gnt_ready;
      p_ovr  <= ld_en && (ld_idx == gnt_idx);
      p_idx  <= gnt_idx;
      p_bank <= g_bank;
      p_row  <= ents[gnt_idx].row;
    end
  end

  AST_NO_GNT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) !any_vld |-> !gnt_valid); // R3
  AST_GNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n) gnt_valid |-> ents[gnt_idx].vld); // R3
  AST_RETIRE: assert property (@(posedge clk) disable iff (!rst_n) (p_acc && !p_ovr) |-> !ents[p_idx].vld); // R10
  AST_ROW_OPENED: assert property (@(posedge clk) disable iff (!rst_n) p_acc |-> (open_v[p_bank] && open_row[p_bank] == p_row)); // R10
  AST_HIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (gnt_valid && !gnt_fair && hit_any[g_bank]) |-> gnt_hit); // R4
  AST_FAIR_TOP: assert property (@(posedge clk) disable iff (!rst_n) (gnt_valid && gnt_fair) |-> sd_of(slowdown, ents[gnt_idx].tid) >= sd_max); // R9
endmodule

bind fair_dram_sched fsched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ents(ent_q), .open_v(open_v_q), .open_row(open_row_q),
  .hit_any(bank_hit_any), .slowdown(slowdown), .ld_en(ld_en), .ld_idx(ld_idx),
  .gnt_ready(gnt_ready), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .gnt_fair(gnt_fair)
);

// File: tb/sim_fair_dram_sched.sv
`timescale 1ns/1ps
module sim_fair_dram_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_idx = '0;
  logic [1:0]  ld_thread = '0;
  logic [2:0]  ld_bank = '0;
  logic [7:0]  ld_row = '0, ld_stamp = '0;
  logic [31:0] slowdown = '0;
  logic [7:0]  unfair_level = '0, unfair_limit = '0;
  logic        gnt_ready = 1'b0;
  logic        gnt_valid, gnt_fair;
  logic [3:0]  gnt_idx;

  fair_dram_sched u0 (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bit       m_v[16];
  int       m_thr[16], m_bank[16], m_row[16], m_st[16];
  bit       m_ov[8];
  int       m_orow[8];
  int       m_sd[4];

  typedef struct { int idx; bit fair; string tag; } exp_t;
  exp_t sb[$];

  function automatic bit m_hit(int i);
    return m_ov[m_bank[i]] && m_orow[m_bank[i]] == m_row[i];
  endfunction

  function automatic int ref_pick(bit fair);
    int best = -1;
    int cand[8];
    if (fair) begin
      for (int i = 0; i < 16; i++) if (m_v[i]) begin
        if (best < 0) best = i;
        else if (m_sd[m_thr[i]] > m_sd[m_thr[best]]) best = i;
        else if (m_sd[m_thr[i]] == m_sd[m_thr[best]] &&
                 (m_st[i] < m_st[best] || (m_st[i] == m_st[best] && m_bank[i] < m_bank[best]))) best = i;
      end
      return best;
    end
    for (int b = 0; b < 8; b++) begin
      cand[b] = -1;
      for (int i = 0; i < 16; i++) if (m_v[i] && m_bank[i] == b) begin
        if (cand[b] < 0) cand[b] = i;
        else if (m_hit(i) && !m_hit(cand[b])) cand[b] = i;
        else if (m_hit(i) == m_hit(cand[b]) && m_st[i] < m_st[cand[b]]) cand[b] = i;
      end
    end
    for (int b = 0; b < 8; b++)
      if (cand[b] >= 0 && (best < 0 || m_st[cand[b]] < m_st[best])) best = cand[b];
    return best;
  endfunction

  task automatic set_sd(int s0, int s1, int s2, int s3);
    m_sd[0] = s0; m_sd[1] = s1; m_sd[2] = s2; m_sd[3] = s3;
    slowdown = {8'(s3), 8'(s2), 8'(s1), 8'(s0)};
  endtask

  task automatic load(int idx, int thr, int bank, int row, int st);
    @(posedge clk); #1;
    ld_en = 1; ld_idx = 4'(idx); ld_thread = 2'(thr); ld_bank = 3'(bank);
    ld_row = 8'(row); ld_stamp = 8'(st);
    @(posedge clk); #1;
    ld_en = 0;
    m_v[idx] = 1; m_thr[idx] = thr; m_bank[idx] = bank; m_row[idx] = row; m_st[idx] = st;
  endtask

  // driver: one accept cycle; optional load of the expected slot in the same cycle
  task automatic issue(string tag, bit with_ld = 0, int thr = 0, int bank = 0, int row = 0, int st = 0);
    exp_t e;
    int orow;
    @(posedge clk); #1;
    e.fair = unfair_level > unfair_limit;
    e.idx  = ref_pick(e.fair);
    e.tag  = tag;
    sb.push_back(e);
    gnt_ready = 1;
    if (with_ld && e.idx >= 0) begin
      ld_en = 1; ld_idx = 4'(e.idx); ld_thread = 2'(thr); ld_bank = 3'(bank);
      ld_row = 8'(row); ld_stamp = 8'(st);
    end
    @(posedge clk); #1;
    gnt_ready = 0; ld_en = 0;
    if (e.idx >= 0) begin
      orow = m_row[e.idx];
      m_ov[m_bank[e.idx]] = 1; m_orow[m_bank[e.idx]] = orow;
      if (with_ld) begin
        m_thr[e.idx] = thr; m_bank[e.idx] = bank; m_row[e.idx] = row; m_st[e.idx] = st;
      end else m_v[e.idx] = 0;
    end
  endtask

  // monitor: pop and compare mid-cycle
  always @(negedge clk) begin
    if (gnt_ready && sb.size() > 0) begin
      exp_t e;
      bit ok;
      e = sb.pop_front();
      n_chk++;
      if (e.idx < 0) ok = !gnt_valid;
      else ok = gnt_valid && int'(gnt_idx) == e.idx && gnt_fair == e.fair;
      if (!ok) begin
        n_fail++;
        $display("FAIL %s: got valid=%0b idx=%0d fair=%0b, expected idx=%0d fair=%0b",
                 e.tag, gnt_valid, gnt_idx, gnt_fair, e.idx, e.fair);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    set_sd(10, 50, 50, 90);
    unfair_level = 5; unfair_limit = 10;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    n_chk++;
    if (gnt_valid !== 1'b0) begin
      n_fail++; $display("FAIL R1: got gnt_valid=%0b, expected 0", gnt_valid);
    end
    issue("R1 R3 empty after reset");

    // R5 age inside a closed bank, then R4 hit over older
    load(0, 0, 0, 5, 10);
    load(1, 1, 0, 7, 20);
    issue("R5 oldest in bank");            // slot 0, opens row 5
    load(2, 2, 0, 9, 5);
    load(3, 3, 0, 5, 30);
    issue("R4 hit preferred");              // slot 3
    issue("R5 oldest among misses");        // slot 2
    issue("R4 R5 last entry");              // slot 1
    issue("R3 drained");

    // R5 equal stamps -> lower slot
    load(6, 0, 1, 3, 8);
    load(4, 0, 1, 4, 8);
    issue("R5 stamp tie lower slot");       // slot 4
    issue("R5 remaining");

    // R6 across banks
    load(7, 1, 3, 1, 40);
    load(9, 1, 5, 1, 15);
    load(8, 1, 2, 1, 15);
    issue("R6 stamp tie lower bank");       // slot 8
    issue("R6 next oldest");                // slot 9
    issue("R6 last");                        // slot 7

    // R7 boundary: level equal to limit stays in throughput mode
    load(0, 1, 0, 2, 3);
    load(1, 3, 0, 2, 60);
    load(2, 3, 1, 2, 50);
    load(3, 2, 2, 2, 1);
    unfair_level = 10; unfair_limit = 10;
    issue("R7 equal level throughput");     // slot 3 oldest
    load(3, 2, 2, 2, 1);
    unfair_level = 11;
    issue("R7 R9 fair highest slowdown");   // slot 2
    issue("R8 oldest of top thread in bank"); // slot 1
    issue("R9 slowdown tie older");         // slot 3
    issue("R8 R9 last");                     // slot 0
    issue("R3 empty in fair mode");

    // R8: bank picks top-slowdown thread over older low-slowdown one
    set_sd(10, 20, 30, 5);
    load(5, 0, 4, 1, 2);
    load(6, 2, 4, 1, 70);
    load(7, 1, 6, 1, 70);
    issue("R8 top thread in bank");         // slot 6
    unfair_level = 0;
    issue("R6 throughput after mode drop"); // slot 5
    issue("R6 last entry");                  // slot 7

    // R2 load wins over same-cycle retirement
    load(10, 0, 7, 4, 9);
    issue("R2 R10 retire with reload", 1, 1, 7, 6, 12); // slot 10, reloaded
    issue("R2 reloaded entry");              // slot 10 again
    issue("R2 R10 empty after");

    done = 1;
    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule